// File: doc/BRIEF.md
# Receive Cell FIFO with Near-Empty Flag

This block sits between a physical-layer cell receiver and the ATM-layer device that drains received cells. The line side writes 53-byte cells one byte per `wclk` cycle and marks the first byte of each cell. The ATM layer pulls bytes on its own clock, `rclk`, with an active-low read enable. Each byte comes out one cycle after the enable is sampled, together with a start-of-cell marker. The two clock domains exchange only Gray-coded pointers through two-stage synchronisers.

Cells are admitted whole. When a new cell starts and the line side cannot see room for all of its bytes, the whole cell is discarded and a one-cycle drop event is raised. Bytes that belong to no accepted cell are ignored. On the read side a registered flag warns that the FIFO is close to empty. The margin is programmable from 0 to 4 bytes, and the active level is selectable. A registered output-enable stands in for tristate drive of the data and start-of-cell outputs. It follows the read enable when tristate mode is selected and stays on otherwise.

Top module: `rxcell_fifo`

## Requirements
- R1: Bytes of accepted cells are read out in exactly the order they were written, whatever the ratio between the two clocks.
- R2: `r_soc` is high together with `r_valid` on the first byte of each cell (the byte written with `w_soc` high) and low on the other 52 bytes.
- R3: When `w_valid` and `w_soc` are both high and the write side sees fewer than 53 free entries, the whole cell is discarded, `cell_drop` is high for exactly one `wclk` cycle, and none of that cell's bytes can be read. Later cells are accepted again once room appears.
- R4: When `rd_en_n` is sampled low at an `rclk` edge and a byte is readable, that byte appears on `r_data` with `r_valid` high from that edge until the next one. When `rd_en_n` is sampled high, or nothing is readable, `r_valid` is low and no byte is consumed.
- R5: The near-empty condition is true when the number of readable bytes left after the read made at that edge is at most the margin. The margin is `cfg_margin` for codes 0 to 4, and codes 5 to 7 act as 4. The flag is registered on `rclk`.
- R6: With `cfg_cav_pol` = 1, `r_cav` is high while near-empty. With `cfg_cav_pol` = 0, `r_cav` is high while more bytes than the margin are readable.
- R7: With `cfg_tsen` = 1, `r_oe` is high only in a cycle whose opening `rclk` edge sampled `rd_en_n` low. With `cfg_tsen` = 0, `r_oe` is high in every cycle after reset.
- R8: During and after reset, with nothing written, `r_valid`, `r_soc` and `cell_drop` are low and the near-empty condition is true.
- R9: Bytes presented with `w_valid` high and `w_soc` low outside an accepted cell are ignored. This covers bytes before any start of cell and bytes after the 53rd byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Line-side write clock |
| wrst_n | input | 1 | Write-domain synchronous reset, active low |
| w_valid | input | 1 | Write byte strobe |
| w_soc | input | 1 | Marks the first byte of a cell |
| w_data | input | 8 | Write byte |
| cell_drop | output | 1 | One-cycle pulse when an arriving cell is discarded |
| rclk | input | 1 | Reader-side FIFO clock |
| rrst_n | input | 1 | Read-domain synchronous reset, active low |
| rd_en_n | input | 1 | Read enable, active low |
| cfg_margin | input | 3 | Near-empty margin in bytes (0 to 4; larger codes act as 4) |
| cfg_cav_pol | input | 1 | Flag polarity: 1 = high when near-empty |
| cfg_tsen | input | 1 | Tristate mode: outputs enabled only after enable sampled low |
| r_data | output | 8 | Read byte |
| r_soc | output | 1 | Start-of-cell marker for `r_data` |
| r_valid | output | 1 | `r_data` holds a byte read at the last edge |
| r_oe | output | 1 | Output-drive enable for `r_data` and `r_soc` |
| r_cav | output | 1 | Near-empty / cell-available flag |

## Verification
The bench uses the default parameters: a 128-byte store (7 address bits) and 53-byte cells. With these values, two whole cells fit with 22 bytes spare, so a third cell written back to back is guaranteed to meet the drop rule. A fourth cell written after draining checks that admission recovers. The write clock runs at a 14 ns period against a 10 ns read clock, so the pointer synchronisers cross in both directions at an uneven phase. Every margin code from 0 to 5 is swept against both flag polarities. The sweep covers the clamp and the last few bytes of a cell.

// File: rtl/rxq_pkg.sv
// Package: shared constants and the stored entry layout for the receive cell FIFO.
// Assumes byte-wide cells with a start-of-cell marker carried beside each byte.
package rxq_pkg;
    localparam int CELL_BYTES = 53;

    typedef struct packed {
        logic       soc;
        logic [7:0] data;
    } rxq_entry_t;
endpackage

// File: rtl/rxq_ptr_sync.sv
// Module: two-stage synchroniser for a Gray-coded pointer crossing clock domains.
// Assumes the source changes at most one bit per source clock (Gray code).
module rxq_ptr_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Capture the foreign pointer through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/rxq_wr_ctrl.sv
// Module: write-side control. Admits whole cells when space allows, discards the
// rest, drives the store write port and publishes the Gray write pointer.
// Assumes well-formed cells of CELL_LEN bytes with CELL_LEN < 2**ADDR_W.
module rxq_wr_ctrl #(
    parameter int ADDR_W   = 7,
    parameter int CELL_LEN = 53,
    localparam int PTR_W   = ADDR_W + 1
) (
    input  logic                 wclk,
    input  logic                 wrst_n,
    input  logic                 w_valid,
    input  logic                 w_soc,
    input  logic [7:0]           w_data,
    input  logic [PTR_W-1:0]     rq_rgray,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_waddr,
    output rxq_pkg::rxq_entry_t  mem_wdata,
    output logic [PTR_W-1:0]     wgray,
    output logic                 cell_drop
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int CNT_W = $clog2(CELL_LEN + 1);

    function automatic logic [PTR_W-1:0] g2b(input logic [PTR_W-1:0] g);
        logic [PTR_W-1:0] b;
        b[PTR_W-1] = g[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    logic [PTR_W-1:0] wptr, wptr_next, rq_bin, used, free_cnt;
    logic [CNT_W-1:0] left;
    logic             in_cell, start, free_ok, admit, cont, w_run;

    // Decode the cell start decision and the write strobe.
    always_comb begin
        rq_bin    = g2b(rq_rgray);
        used      = wptr - rq_bin;
        free_cnt  = PTR_W'(DEPTH) - used;
        free_ok   = free_cnt >= PTR_W'(CELL_LEN);
        start     = w_valid & w_soc;
        admit     = start & free_ok;
        cont      = w_valid & ~w_soc & in_cell;
        mem_we    = admit | cont;
        mem_waddr = wptr[ADDR_W-1:0];
        mem_wdata = '{soc: w_soc, data: w_data};
        wptr_next = wptr + PTR_W'(mem_we);
    end

    // Advance the write pointer, track the cell in progress and flag drops.
    always_ff @(posedge wclk) begin
        if (!wrst_n) begin
            wptr      <= '0;
            wgray     <= '0;
            in_cell   <= 1'b0;
            left      <= '0;
            cell_drop <= 1'b0;
            w_run     <= 1'b0;
        end else begin
            w_run     <= 1'b1;
            wptr      <= wptr_next;
            wgray     <= wptr_next ^ (wptr_next >> 1);
            cell_drop <= start & ~free_ok;
            if (admit) begin
                in_cell <= 1'b1;
                left    <= CNT_W'(CELL_LEN - 1);
            end else if (start) begin
                in_cell <= 1'b0;
            end else if (cont) begin
                left <= left - CNT_W'(1);
                if (left == CNT_W'(1)) in_cell <= 1'b0;
            end
        end
    end

    // R3: the store never holds more than its depth.
    p_no_overflow_r3: assert property (@(posedge wclk) disable iff (!wrst_n)
        used <= PTR_W'(DEPTH));

    // R3: in the cycle a drop is reported, the rejected start byte was not stored.
    p_drop_no_store_r3: assert property (@(posedge wclk) disable iff (!wrst_n || !w_run)
        cell_drop |-> $past(!mem_we));

    // R9: no write happens without a strobe.
    p_write_needs_strobe_r9: assert property (@(posedge wclk) disable iff (!wrst_n)
        mem_we |-> w_valid);
endmodule

// File: rtl/rxq_rd_ctrl.sv
// Module: read-side control. Pops one byte per sampled-low enable, registers the
// outputs, the drive enable and the near-empty condition.
// Assumes cfg inputs are held steady while reading.
module rxq_rd_ctrl #(
    parameter int ADDR_W     = 7,
    parameter int MARGIN_W   = 3,
    parameter int MAX_MARGIN = 4,
    localparam int PTR_W     = ADDR_W + 1
) (
    input  logic                 rclk,
    input  logic                 rrst_n,
    input  logic                 rd_en_n,
    input  logic [MARGIN_W-1:0]  cfg_margin,
    input  logic                 cfg_tsen,
    input  logic [PTR_W-1:0]     rq_wgray,
    input  rxq_pkg::rxq_entry_t  mem_rdata,
    output logic [ADDR_W-1:0]    mem_raddr,
    output logic [PTR_W-1:0]     rgray,
    output logic [7:0]           r_data,
    output logic                 r_soc,
    output logic                 r_valid,
    output logic                 r_oe,
    output logic                 near_q
);
    localparam int DEPTH = 1 << ADDR_W;

    function automatic logic [PTR_W-1:0] g2b(input logic [PTR_W-1:0] g);
        logic [PTR_W-1:0] b;
        b[PTR_W-1] = g[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    logic [PTR_W-1:0]    rptr, rptr_next, wq_bin, level, level_after;
    logic [MARGIN_W-1:0] eff_margin;
    logic                pop, near_d, r_run;

    // Work out the pop, the level after it and the clamped margin.
    always_comb begin
        wq_bin      = g2b(rq_wgray);
        level       = wq_bin - rptr;
        pop         = ~rd_en_n & (level != '0);
        rptr_next   = rptr + PTR_W'(pop);
        level_after = wq_bin - rptr_next;
        eff_margin  = (cfg_margin > MARGIN_W'(MAX_MARGIN)) ? MARGIN_W'(MAX_MARGIN) : cfg_margin;
        near_d      = level_after <= PTR_W'(eff_margin);
        mem_raddr   = rptr[ADDR_W-1:0];
    end

    // Register the read pointer, output byte, drive enable and flag.
    always_ff @(posedge rclk) begin
        if (!rrst_n) begin
            rptr    <= '0;
            rgray   <= '0;
            r_data  <= '0;
            r_soc   <= 1'b0;
            r_valid <= 1'b0;
            r_oe    <= 1'b0;
            near_q  <= 1'b1;
            r_run   <= 1'b0;
        end else begin
            r_run   <= 1'b1;
            rptr    <= rptr_next;
            rgray   <= rptr_next ^ (rptr_next >> 1);
            r_valid <= pop;
            r_soc   <= pop & mem_rdata.soc;
            if (pop) r_data <= mem_rdata.data;
            r_oe    <= ~cfg_tsen | ~rd_en_n;
            near_q  <= near_d;
        end
    end

    // R4: a byte only appears after the enable was sampled low.
    p_valid_needs_enable_r4: assert property (@(posedge rclk) disable iff (!rrst_n || !r_run)
        r_valid |-> $past(!rd_en_n));

    // R7: in tristate mode an idle enable turns the drive off.
    p_oe_off_r7: assert property (@(posedge rclk) disable iff (!rrst_n || !r_run)
        ($past(cfg_tsen) && $past(rd_en_n)) |-> !r_oe);

    // R7: with tristate mode off the outputs are always driven.
    p_oe_on_r7: assert property (@(posedge rclk) disable iff (!rrst_n || !r_run)
        $past(!cfg_tsen) |-> r_oe);

    // R5: the readable level never exceeds the store depth.
    p_level_bound_r5: assert property (@(posedge rclk) disable iff (!rrst_n)
        level <= PTR_W'(DEPTH));
endmodule

// File: rtl/rxcell_fifo.sv
// Module: top of the receive cell FIFO. Holds the byte store and ties the write
// control, read control and pointer synchronisers together.
// Assumes wclk and rclk are unrelated; each domain has its own synchronous reset.
module rxcell_fifo #(
    parameter int ADDR_W     = 7,
    parameter int CELL_LEN   = rxq_pkg::CELL_BYTES,
    parameter int MARGIN_W   = 3,
    parameter int MAX_MARGIN = 4
) (
    input  logic                wclk,
    input  logic                wrst_n,
    input  logic                w_valid,
    input  logic                w_soc,
    input  logic [7:0]          w_data,
    output logic                cell_drop,
    input  logic                rclk,
    input  logic                rrst_n,
    input  logic                rd_en_n,
    input  logic [MARGIN_W-1:0] cfg_margin,
    input  logic                cfg_cav_pol,
    input  logic                cfg_tsen,
    output logic [7:0]          r_data,
    output logic                r_soc,
    output logic                r_valid,
    output logic                r_oe,
    output logic                r_cav
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PTR_W = ADDR_W + 1;

    rxq_pkg::rxq_entry_t mem [DEPTH];
    rxq_pkg::rxq_entry_t mem_wdata, mem_rdata;
    logic [ADDR_W-1:0]   mem_waddr, mem_raddr;
    logic                mem_we, near_q;
    logic [PTR_W-1:0]    wgray, rgray, rq_wgray, rq_rgray;

    // Store one entry per accepted write.
    always_ff @(posedge wclk) begin
        if (mem_we) mem[mem_waddr] <= mem_wdata;
    end

    assign mem_rdata = mem[mem_raddr];

    rxq_wr_ctrl #(.ADDR_W(ADDR_W), .CELL_LEN(CELL_LEN)) u_wr (
        .wclk(wclk), .wrst_n(wrst_n), .w_valid(w_valid), .w_soc(w_soc),
        .w_data(w_data), .rq_rgray(rq_rgray), .mem_we(mem_we),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .wgray(wgray),
        .cell_drop(cell_drop)
    );

    rxq_ptr_sync #(.W(PTR_W)) u_sync_r2w (
        .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rq_rgray)
    );

    rxq_ptr_sync #(.W(PTR_W)) u_sync_w2r (
        .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(rq_wgray)
    );

    rxq_rd_ctrl #(.ADDR_W(ADDR_W), .MARGIN_W(MARGIN_W), .MAX_MARGIN(MAX_MARGIN)) u_rd (
        .rclk(rclk), .rrst_n(rrst_n), .rd_en_n(rd_en_n), .cfg_margin(cfg_margin),
        .cfg_tsen(cfg_tsen), .rq_wgray(rq_wgray), .mem_rdata(mem_rdata),
        .mem_raddr(mem_raddr), .rgray(rgray), .r_data(r_data), .r_soc(r_soc),
        .r_valid(r_valid), .r_oe(r_oe), .near_q(near_q)
    );

    // R6: apply the selected polarity to the registered near-empty condition.
    assign r_cav = cfg_cav_pol ? near_q : ~near_q;

    // R2: a start-of-cell marker always travels with a valid byte.
    p_soc_with_valid_r2: assert property (@(posedge rclk) disable iff (!rrst_n)
        r_soc |-> r_valid);
endmodule

// File: tb/tb_rxcell_fifo.sv
`timescale 1ns/1ps
module tb_rxcell_fifo;
    localparam int CLK_PERIOD  = 10;
    localparam int WCLK_PERIOD = 14;
    localparam int CELL        = 53;

    logic       wclk = 0, rclk = 0;
    logic       wrst_n = 0, rrst_n = 0;
    logic       w_valid = 0, w_soc = 0;
    logic [7:0] w_data = 0;
    logic       rd_en_n = 1;
    logic [2:0] cfg_margin = 0;
    logic       cfg_cav_pol = 1, cfg_tsen = 0;
    logic       cell_drop, r_soc, r_valid, r_oe, r_cav;
    logic [7:0] r_data;

    int checks = 0, failures = 0, drop_cnt = 0;
    bit done = 0;

    always #(WCLK_PERIOD / 2) wclk = ~wclk;
    always #(CLK_PERIOD / 2) rclk = ~rclk;

    rxcell_fifo dut (
        .wclk(wclk), .wrst_n(wrst_n), .w_valid(w_valid), .w_soc(w_soc), .w_data(w_data),
        .cell_drop(cell_drop), .rclk(rclk), .rrst_n(rrst_n), .rd_en_n(rd_en_n),
        .cfg_margin(cfg_margin), .cfg_cav_pol(cfg_cav_pol), .cfg_tsen(cfg_tsen),
        .r_data(r_data), .r_soc(r_soc), .r_valid(r_valid), .r_oe(r_oe), .r_cav(r_cav)
    );

    always @(negedge wclk) if (cell_drop) drop_cnt++;

    function automatic logic [7:0] pat(input int tag, input int i);
        return 8'((tag * 29 + i * 3 + 1) & 255);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (10) @(negedge rclk);
    endtask

    task automatic write_cell(input int tag, input int extra);
        for (int i = 0; i < CELL + extra; i++) begin
            @(negedge wclk);
            w_valid = 1; w_soc = (i == 0); w_data = pat(tag, i);
        end
        @(negedge wclk);
        w_valid = 0; w_soc = 0;
    endtask

    task automatic read_empty(input string req);
        @(negedge rclk); rd_en_n = 0;
        @(negedge rclk);
        check(r_valid == 0, req, r_valid, 0);
        rd_en_n = 1;
    endtask

    // Reads one cell; optionally checks the flag after each byte.
    task automatic read_cell(input int tag, input bit chk_flag);
        int m;
        bit near;
        m = (cfg_margin > 4) ? 4 : int'(cfg_margin);
        @(negedge rclk);
        for (int i = 0; i < CELL; i++) begin
            rd_en_n = 0;
            @(negedge rclk);
            check(r_valid == 1, "R4 valid", r_valid, 1);
            check(r_data == pat(tag, i), "R1 byte order", r_data, pat(tag, i));
            check(r_soc == (i == 0), "R2 soc", r_soc, (i == 0));
            if (chk_flag) begin
                near = (CELL - 1 - i) <= m;
                check(r_cav == (cfg_cav_pol ? near : !near), "R5 R6 flag", r_cav,
                      cfg_cav_pol ? near : !near);
            end
        end
        rd_en_n = 1;
    endtask

    task automatic t_reset();
        wrst_n = 0; rrst_n = 0;
        repeat (4) @(negedge wclk);
        @(negedge rclk);
        check(r_valid == 0 && r_soc == 0, "R8 outputs idle in reset", r_valid, 0);
        check(r_cav == 1, "R8 near-empty in reset", r_cav, 1);
        wrst_n = 1; rrst_n = 1;
        @(negedge rclk); @(negedge rclk);
        check(cell_drop == 0, "R8 no drop", cell_drop, 0);
        check(r_cav == 1, "R8 empty flag", r_cav, 1);
        check(r_oe == 1, "R7 driven with tristate off", r_oe, 1);
    endtask

    task automatic t_basic();
        write_cell(1, 0);
        write_cell(2, 0);
        settle();
        read_cell(1, 0);
        read_cell(2, 0);
        check(r_oe == 1, "R7 driven with tristate off", r_oe, 1);
        read_empty("R4 empty read");
        @(negedge rclk);
        check(r_valid == 0, "R4 idle enable", r_valid, 0);
    endtask

    task automatic t_overflow();
        int d0;
        d0 = drop_cnt;
        write_cell(3, 0);
        write_cell(4, 0);
        write_cell(5, 0);
        settle();
        check(drop_cnt - d0 == 1, "R3 one drop pulse", drop_cnt - d0, 1);
        read_cell(3, 0);
        read_cell(4, 0);
        read_empty("R3 dropped cell not readable");
        settle();
        write_cell(6, 0);
        settle();
        check(drop_cnt - d0 == 1, "R3 admission recovers", drop_cnt - d0, 1);
        read_cell(6, 0);
        read_empty("R3 empty after recovery");
    endtask

    task automatic t_stray();
        for (int i = 0; i < 5; i++) begin
            @(negedge wclk); w_valid = 1; w_soc = 0; w_data = 8'hA5;
        end
        @(negedge wclk); w_valid = 0;
        settle();
        read_empty("R9 stray bytes before a cell");
        write_cell(7, 4);
        settle();
        read_cell(7, 0);
        read_empty("R9 bytes past cell end");
    endtask

    task automatic t_flag();
        for (int p = 0; p < 2; p++) begin
            for (int m = 0; m < 6; m++) begin
                cfg_cav_pol = p[0]; cfg_margin = 3'(m);
                write_cell(10 + m, 0);
                settle();
                check(r_cav == !cfg_cav_pol, "R6 full cell not near-empty", r_cav, !cfg_cav_pol);
                read_cell(10 + m, 1);
                settle();
            end
        end
        cfg_cav_pol = 1; cfg_margin = 0;
    endtask

    task automatic t_tristate();
        cfg_tsen = 1;
        @(negedge rclk); @(negedge rclk);
        check(r_oe == 0, "R7 off while idle", r_oe, 0);
        write_cell(20, 0);
        settle();
        check(r_oe == 0, "R7 off before read", r_oe, 0);
        @(negedge rclk); rd_en_n = 0;
        @(negedge rclk);
        check(r_oe == 1, "R7 on after enable", r_oe, 1);
        check(r_valid == 1 && r_soc == 1, "R7 first byte with drive", r_soc, 1);
        rd_en_n = 1;
        @(negedge rclk);
        check(r_oe == 0, "R7 off after enable released", r_oe, 0);
        check(r_valid == 0, "R4 no pop when released", r_valid, 0);
        for (int i = 1; i < CELL; i++) begin
            rd_en_n = 0;
            @(negedge rclk);
            check(r_data == pat(20, i) && r_oe == 1, "R1 R7 remaining bytes", r_data, pat(20, i));
        end
        rd_en_n = 1;
        read_empty("R4 empty in tristate mode");
        cfg_tsen = 0;
    endtask

    initial begin
        t_reset();
        t_basic();
        t_overflow();
        t_stray();
        t_flag();
        t_tristate();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule